// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Read Cache

This block is a direct-mapped read cache whose frames each carry one tag but hold several sub-blocks, and each sub-block has a valid bit of its own. The unit fetched from the next memory level is a single sub-block (one word), never a whole frame. A lookup that misses is classified. A **block-level miss** means the frame belongs to another tag, or none of its sub-blocks is valid. A **sub-block-level miss** means the tag matches and at least one sibling is valid, but the requested sub-block is not.

The processor presents a word address with a one-cycle `cpu_req` pulse while the cache is idle. The cache answers with a one-cycle `cpu_ready` pulse carrying the data, a hit flag and the miss class. On a miss it issues one request for the missing word on the next-level port, waits for the response, stores it, and then answers.

The controller has five states. `ST_IDLE` accepts a request and moves to `ST_LOOKUP`. `ST_LOOKUP` compares the tag and valid bits. On a hit it returns to `ST_IDLE`. On a miss it moves to `ST_FILL_REQ`, and on a block-level miss it also rewrites the tag and clears every valid bit of the frame. `ST_FILL_REQ` drives the memory request for one cycle and moves to `ST_FILL_WAIT`. `ST_FILL_WAIT` stays until the response arrives, writes the word, sets its valid bit, and moves to `ST_RESPOND`. `ST_RESPOND` raises ready and returns to `ST_IDLE`.

Top module: `subblk_cache`

## Requirements
- R1: After reset no sub-block is valid and `cpu_ready` and `mem_req` are low. The first access to any address is therefore a block-level miss, even when its tag field is zero.
- R2: A hit (tag matches and the sub-block is valid) raises `cpu_ready` with `cpu_hit`=1, `cpu_blk_miss`=0 and the stored word in the cycle after acceptance, with no memory request.
- R3: A block-level miss is reported with `cpu_hit`=0 and `cpu_blk_miss`=1. It happens when the tag differs, or when the tag matches but no sub-block of the frame is valid.
- R4: A block-level miss rewrites the frame's tag and clears the valid bits of all its other sub-blocks, so their old contents can no longer hit.
- R5: A sub-block-level miss (tag matches, requested sub-block invalid, another sub-block valid) is reported with `cpu_hit`=0 and `cpu_blk_miss`=0. It keeps the tag and leaves the other valid bits and words unchanged.
- R6: Each miss issues exactly one single-cycle `mem_req`, with `mem_addr` equal to the full requested word address. A hit issues none.
- R7: On a miss, `mem_req` is high in the second cycle after acceptance. `cpu_ready` stays low until the cycle after `mem_rsp_valid`, and then rises with `cpu_hit`=0 and `cpu_rdata` equal to `mem_rsp_data`. With a response L cycles after the request, ready comes 2+L cycles after the lookup cycle.
- R8: A `cpu_req` that arrives while a request is in progress is ignored. It causes no memory request and no ready pulse.
- R9: Address bits [1:0] select the sub-block, bits [5:2] select one of 16 frames, and the remaining upper bits form the tag. Addresses with different frame indices coexist; addresses with the same index and different tags evict each other.
- R10: `cpu_ready` is a one-cycle pulse, given once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Read request pulse, taken only when idle |
| cpu_addr | input | ADDR_W | Word address of the read |
| cpu_ready | output | 1 | One-cycle pulse delivering the word |
| cpu_hit | output | 1 | With ready: 1 = hit, 0 = served by refill |
| cpu_blk_miss | output | 1 | With ready: 1 = block-level miss, 0 otherwise |
| cpu_rdata | output | DATA_W | Read data, valid with ready |
| mem_req | output | 1 | One-cycle sub-block fetch request |
| mem_addr | output | ADDR_W | Word address being fetched |
| mem_rsp_valid | input | 1 | Fetch response strobe |
| mem_rsp_data | input | DATA_W | Fetched word |

## Verification
The hardest case to reach from the ports is a tag match on a frame whose valid bits were all cleared by a block-level miss. That case must be a sub-block miss, not a stale hit. The stimulus reaches it by filling two sub-blocks under one tag, evicting the frame with a conflicting tag, and then reading a sibling under the new tag. A refill counter changes every returned word, so a stale hit shows up as a data mismatch as well as a wrong hit flag. A second hard case is the request poked in during the refill wait: it is injected while a slow response is pending, and the bench counts memory requests and ready pulses afterwards.

// File: rtl/subblk_cache_pkg.sv
package subblk_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_RESPOND
    } ctrl_state_e;

endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
    parameter int FRAMES = 16,
    parameter int SUBS   = 4,
    parameter int TAG_W  = 10,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int SUB_W = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [SUB_W-1:0] sub,
    input  logic [TAG_W-1:0] tag,
    input  logic             alloc_en,
    input  logic             fill_en,
    output logic             tag_match,
    output logic             sub_valid,
    output logic             any_valid
);

    logic [TAG_W-1:0] tag_q   [FRAMES];
    logic [SUBS-1:0]  valid_q [FRAMES];

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[f]   <= '0;
                valid_q[f] <= '0;
            end else if (alloc_en && idx == IDX_W'(f)) begin
                tag_q[f]   <= tag;
                valid_q[f] <= '0;
            end else if (fill_en && idx == IDX_W'(f)) begin
                valid_q[f][sub] <= 1'b1;
            end
        end
    end

    always_comb begin
        tag_match = (tag_q[idx] == tag);
        sub_valid = valid_q[idx][sub];
        any_valid = |valid_q[idx];
    end

    // R4: a block-level allocation leaves the frame with no valid sub-block
    p_alloc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (valid_q[$past(idx)] == '0));

    // R7: a refill write marks its sub-block valid
    p_fill_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(idx)][$past(sub)]);

    // R5: a refill keeps the frame's tag
    p_fill_keeps_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (tag_q[$past(idx)] == $past(tag_q[idx])));

    // R3: allocation and refill never coincide
    p_alloc_fill_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_en && fill_en));

endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
    parameter int FRAMES = 16,
    parameter int SUBS   = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int SUB_W = $clog2(SUBS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SUB_W-1:0]  sub,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] word_q [FRAMES][SUBS];

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        for (genvar s = 0; s < SUBS; s++) begin : g_sub
            always_ff @(posedge clk) begin
                if (wr_en && idx == IDX_W'(f) && sub == SUB_W'(s)) begin
                    word_q[f][s] <= wr_data;
                end
            end
        end
    end

    assign rd_data = word_q[idx][sub];

endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import subblk_cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic tag_match,
    input  logic sub_valid,
    input  logic any_valid,
    input  logic mem_rsp_valid,
    output logic accept,
    output logic alloc_en,
    output logic fill_en,
    output logic mem_req,
    output logic cpu_ready,
    output logic cpu_hit,
    output logic cpu_blk_miss
);

    ctrl_state_e state_q, state_d;
    logic        blk_q;
    logic        frame_live;
    logic        hit_now;

    assign frame_live = tag_match && any_valid;
    assign hit_now    = frame_live && sub_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP:    state_d = hit_now ? ST_IDLE : ST_FILL_REQ;
            ST_FILL_REQ:  state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rsp_valid) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOOKUP) blk_q <= !frame_live;
        end
    end

    always_comb begin
        accept       = 1'b0;
        alloc_en     = 1'b0;
        fill_en      = 1'b0;
        mem_req      = 1'b0;
        cpu_ready    = 1'b0;
        cpu_hit      = 1'b0;
        cpu_blk_miss = 1'b0;
        unique case (state_q)
            ST_IDLE:      accept = cpu_req;
            ST_LOOKUP: begin
                cpu_ready = hit_now;
                cpu_hit   = hit_now;
                alloc_en  = !frame_live;
            end
            ST_FILL_REQ:  mem_req = 1'b1;
            ST_FILL_WAIT: fill_en = mem_rsp_valid;
            ST_RESPOND: begin
                cpu_ready    = 1'b1;
                cpu_blk_miss = blk_q;
            end
            default: ;
        endcase
    end

    // R10: ready never lasts two cycles
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R6: one memory request cycle per miss
    p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R2: a hit returns to idle without touching memory
    p_hit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_hit) |=> (state_q == ST_IDLE && !mem_req));

    // R7: the response is delivered the cycle after it arrives
    p_rsp_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL_WAIT && mem_rsp_valid) |=> (cpu_ready && !cpu_hit));

    // R8: a request during the wait does not disturb it
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL_WAIT && cpu_req && !mem_rsp_valid) |=> (state_q == ST_FILL_WAIT));

endmodule

// File: rtl/subblk_cache.sv
module subblk_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int FRAMES = 16,
    parameter int SUBS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic              cpu_blk_miss,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int SUB_W = $clog2(SUBS);
    localparam int IDX_W = $clog2(FRAMES);
    localparam int TAG_W = ADDR_W - IDX_W - SUB_W;

    logic [ADDR_W-1:0] addr_q;
    logic [SUB_W-1:0]  a_sub;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic accept, alloc_en, fill_en;
    logic tag_match, sub_valid, any_valid;

    assign a_sub    = addr_q[SUB_W-1:0];
    assign a_idx    = addr_q[SUB_W +: IDX_W];
    assign a_tag    = addr_q[ADDR_W-1 -: TAG_W];
    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= cpu_addr;
    end

    sc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .tag_match    (tag_match),
        .sub_valid    (sub_valid),
        .any_valid    (any_valid),
        .mem_rsp_valid(mem_rsp_valid),
        .accept       (accept),
        .alloc_en     (alloc_en),
        .fill_en      (fill_en),
        .mem_req      (mem_req),
        .cpu_ready    (cpu_ready),
        .cpu_hit      (cpu_hit),
        .cpu_blk_miss (cpu_blk_miss)
    );

    sc_tag_store #(.FRAMES(FRAMES), .SUBS(SUBS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (a_idx),
        .sub      (a_sub),
        .tag      (a_tag),
        .alloc_en (alloc_en),
        .fill_en  (fill_en),
        .tag_match(tag_match),
        .sub_valid(sub_valid),
        .any_valid(any_valid)
    );

    sc_data_store #(.FRAMES(FRAMES), .SUBS(SUBS), .DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .wr_en  (fill_en),
        .idx    (a_idx),
        .sub    (a_sub),
        .wr_data(mem_rsp_data),
        .rd_data(cpu_rdata)
    );

    // R6: the fetch address is the accepted request address
    p_req_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == $past(addr_q)));

endmodule

// File: tb/subblk_cache_test.sv
module subblk_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_ready, cpu_hit, cpu_blk_miss;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;
    int lat = 1;
    int req_cnt = 0;
    int gen = 0;
    logic [15:0] last_req_addr = '0;
    logic [31:0] last_rsp = '0;
    logic [31:0] shadow [int];
    bit done = 0;

    always #2 clk = ~clk;

    subblk_cache uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_blk_miss(cpu_blk_miss),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] mdata(logic [15:0] a, int g);
        return {a, 16'h0} ^ (32'(g) * 32'h01010101) ^ 32'hC3A5_0000;
    endfunction

    // next-level memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                req_cnt++;
                last_req_addr = mem_addr;
                repeat (lat) @(negedge clk);
                gen++;
                last_rsp = mdata(last_req_addr, gen);
                mem_rsp_data = last_rsp;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one read; exp_hit / exp_blk expected flags; poke injects a busy request
    task automatic access(logic [15:0] a, bit exp_hit, bit exp_blk, bit poke = 0);
        int start_req;
        int k;
        int kexp;
        int early;
        start_req = req_cnt;
        @(negedge clk);
        cpu_addr = a;
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        k = 0;
        early = 0;
        while (!cpu_ready && k < 60) begin
            if (poke && k == 1) begin
                cpu_req = 1'b1;
                cpu_addr = a ^ 16'h0100;
            end else begin
                cpu_req = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        cpu_req = 1'b0;
        kexp = exp_hit ? 0 : 2 + lat;
        chk(k == kexp, exp_hit ? "R2 hit latency" : "R7 miss latency", 32'(k), 32'(kexp));
        chk(cpu_hit == exp_hit, "R2/R3/R5 hit flag", 32'(cpu_hit), 32'(exp_hit));
        chk(cpu_blk_miss == exp_blk, exp_blk ? "R3 block-level class" : "R5 sub-level class",
            32'(cpu_blk_miss), 32'(exp_blk));
        if (exp_hit) begin
            chk(shadow.exists(int'(a)) && cpu_rdata == shadow[int'(a)], "R2 hit data",
                cpu_rdata, shadow.exists(int'(a)) ? shadow[int'(a)] : 32'hx);
            chk(req_cnt == start_req, "R6 no request on hit", 32'(req_cnt - start_req), 0);
        end else begin
            chk(cpu_rdata == last_rsp, "R7 refill data", cpu_rdata, last_rsp);
            chk(req_cnt == start_req + 1, "R6 one request", 32'(req_cnt - start_req), 1);
            chk(last_req_addr == a, "R6 fetch address", 32'(last_req_addr), 32'(a));
            shadow[int'(a)] = last_rsp;
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (cpu_ready || mem_req) early++;
        end
        chk(early == 0, poke ? "R8 busy request ignored" : "R10 single ready pulse",
            32'(early), 0);
        if (poke) chk(req_cnt == start_req + 1, "R8 no extra fetch", 32'(req_cnt - start_req), 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!cpu_ready && !mem_req, "R1 reset outputs", {30'b0, cpu_ready, mem_req}, 0);
        access(16'h0000, 0, 1);           // R1: tag 0 yet all invalid
    endtask

    task automatic t_sub_miss;
        access(16'h0001, 0, 0);           // R5
        access(16'h0003, 0, 0);           // R5
        access(16'h0000, 1, 0);           // R5 sibling kept
        access(16'h0001, 1, 0);           // R2
    endtask

    task automatic t_block_evict;
        access(16'h0040, 0, 1);           // R3 tag differs
        access(16'h0041, 0, 0);           // R4 old valid bits cleared
        access(16'h0040, 1, 0);           // R5 sibling kept
        access(16'h0003, 0, 1);           // R9 conflict evicts
        access(16'h0000, 0, 0);           // R4 cleared again
    endtask

    task automatic t_index;
        access(16'h0004, 0, 1);           // R9 frame 1
        access(16'h003E, 0, 1);           // R9 frame 15
        access(16'hFFC5, 0, 1);           // R9 top tag, frame 1 evicted
        access(16'h003E, 1, 0);           // R9 frame 15 untouched
        access(16'h0000, 1, 0);           // R9 frame 0 untouched
        access(16'h0004, 0, 1);           // R9 frame 1 back
    endtask

    task automatic t_latency_busy;
        lat = 5;
        access(16'h0125, 0, 1, 1);        // R7 slow response, R8 poke
        lat = 1;
        access(16'h0126, 0, 0, 1);        // R8 poke on sub-level miss
        access(16'h0125, 1, 0);           // R2
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sub_miss();
        t_block_evict();
        t_index();
        t_latency_busy();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule